// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This block keeps two inter-processor interrupt channels for each CPU of a cluster: an "other" channel, which any CPU can raise on a set of destinations in one write, and a "self" channel. Each channel has a pending bit and a mask bit. A CPU sees the lowest-numbered unmasked pending channel through its event register. Reading that register hands the interrupt to the CPU and masks the channel in the same access. Software then acknowledges the channel and unmasks it again when it is ready for the next one.

All accesses use one register bus. Each access carries the index of the CPU that makes it. The local registers at the bottom of the map act on the requesting CPU. A second window holds one 128-byte view per CPU, so one CPU can set, clear, mask or unmask another CPU's channels. A hardware interrupt path outside the block offers each CPU an event word. When that word is valid it takes precedence over both channels. Each CPU has a request output that is high while any of its channels is pending and unmasked.

Top module: `ipi_unit`

## Requirements
- R1: After reset, every channel is not pending and is masked. A pending read returns 0, a mask read returns 0x8000_0001, `ipi_req` is 0 and `bus_rvalid` is 0.
- R2: Each read is answered one cycle later with `bus_rvalid` high. A read of 0x000 returns the requesting CPU index, zero-extended.
- R3: A write to 0x008 sets the "other" pending bit of CPU c for every data bit c that is 1 and below NUM_CPU. It never sets any "self" bit, and it ignores bits at or above NUM_CPU.
- R4: A pending bit is set whatever the state of its mask bit. `ipi_req[c]` is high exactly when CPU c has a channel that is both pending and unmasked. A read of 0x00C returns the pending bits, with "other" at bit 0 and "self" at bit 31. A read of 0x010 returns the mask bits in the same two positions.
- R5: A read of 0x004 returns an event word. If `hw_valid` is high for the requesting CPU, the word is that CPU's `hw_word`, unchanged. Otherwise, if "other" is pending and unmasked, the word is 0x0004_0001 (type 4 in bits 23:16, number 1 in bits 15:0). Otherwise, if "self" is pending and unmasked, the word is 0x0004_0002. Otherwise the word is 0.
- R6: An event read that returns an IPI word sets that channel's mask bit and leaves its pending bit set. An event read that returns a hardware word changes no IPI state.
- R7: A write to 0x00C clears the requester's "other" pending bit if data bit 0 is 1, and its "self" pending bit if data bit 31 is 1. All other data bits are ignored.
- R8: A write to 0x010 sets the requester's mask bits selected by data bits 0 and 31. A write to 0x014 clears them.
- R9: A write to 0x018 sets the requester's pending bits selected by data bits 0 and 31.
- R10: Writes to 0x1000 + c*0x80 act on CPU c: +0x0 sets pending bits, +0x4 clears pending bits, +0x8 sets mask bits and +0xC clears mask bits, each using data bits 0 and 31. When c is at or above NUM_CPU the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Index of the CPU making the access |
| bus_rvalid | output | 1 | Read response valid, one cycle after the read |
| bus_rdata | output | 32 | Read response data |
| hw_valid | input | NUM_CPU | Hardware event offered, one bit per CPU |
| hw_word | input | 32*NUM_CPU | Hardware event word, one 32-bit slice per CPU |
| ipi_req | output | NUM_CPU | Per-CPU request: a channel is pending and unmasked |

## Verification
The hardest state to reach is a CPU with both channels pending and unmasked, and the event reads that follow. The first read must return "other" and mask only that channel. The request must stay high because of "self" until a second read masks "self" as well. The stimulus reaches this state by raising "other" through a broadcast send and "self" through the local set register, after an unmask. It then checks the event word, the mask read and the request line after each of the two reads. A second hard case is a hardware word arriving while an IPI is waiting. The bench holds `hw_valid` on a CPU that has an unmasked "other" pending. It checks that the IPI state is left alone, and that the same IPI is delivered once `hw_valid` falls.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   // bus operations produced by the address decoder
   typedef enum logic [3:0] {
      OP_NONE, OP_WHOAMI, OP_EVENT, OP_SEND, OP_ACK, OP_MSET,
      OP_MCLR, OP_SSET, OP_RD_PEND, OP_RD_MASK
   } ipi_op_e;

   typedef struct packed {
      ipi_op_e    op;
      logic       tgt_ok;
   } ipi_cmd_t;

   localparam logic [7:0]  EV_TYPE_IPI = 8'd4;
   localparam logic [15:0] EV_NUM_OTH  = 16'd1;
   localparam logic [15:0] EV_NUM_SLF  = 16'd2;

   // internal pair: index 0 = "other", index 1 = "self"
   function automatic logic [1:0] bus_to_pair(input logic [31:0] w);
      return {w[31], w[0]};
   endfunction

   function automatic logic [31:0] pair_to_bus(input logic [1:0] p);
      return {p[1], 30'd0, p[0]};
   endfunction

   function automatic logic [31:0] ipi_event(input logic [15:0] num);
      return {8'd0, EV_TYPE_IPI, num};
   endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode import ipi_pkg::*; #(
   parameter int NUM_CPU = 4,
   parameter int ADDR_W  = 16,
   parameter int CPU_W   = 2
) (
   input  logic              valid_i,
   input  logic              write_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CPU_W-1:0]  cpu_i,
   output ipi_cmd_t          cmd_o,
   output logic [CPU_W-1:0]  tgt_o
);
   localparam int HI_W = ADDR_W - 12;

   logic       local_hit, view_hit;
   logic [4:0] view_idx;

   assign local_hit = (addr_i[ADDR_W-1:12] == '0) && (addr_i[11:5] == '0) && (addr_i[1:0] == '0);
   assign view_hit  = (addr_i[ADDR_W-1:12] == HI_W'(1)) && (addr_i[6:4] == '0) && (addr_i[1:0] == '0);
   assign view_idx  = addr_i[11:7];

   always_comb begin
      cmd_o  = '{op: OP_NONE, tgt_ok: 1'b0};
      tgt_o  = cpu_i;
      if (valid_i && local_hit) begin
         cmd_o.tgt_ok = int'(cpu_i) < NUM_CPU;
         unique case (addr_i[4:2])
            3'd0: if (!write_i) cmd_o.op = OP_WHOAMI;
            3'd1: if (!write_i) cmd_o.op = OP_EVENT;
            3'd2: if (write_i)  cmd_o.op = OP_SEND;
            3'd3: cmd_o.op = write_i ? OP_ACK : OP_RD_PEND;
            3'd4: cmd_o.op = write_i ? OP_MSET : OP_RD_MASK;
            3'd5: if (write_i)  cmd_o.op = OP_MCLR;
            3'd6: if (write_i)  cmd_o.op = OP_SSET;
            default: cmd_o.op = OP_NONE;
         endcase
      end else if (valid_i && view_hit && write_i) begin
         cmd_o.tgt_ok = int'(view_idx) < NUM_CPU;
         tgt_o        = CPU_W'(view_idx);
         unique case (addr_i[3:2])
            2'd0: cmd_o.op = OP_SSET;
            2'd1: cmd_o.op = OP_ACK;
            2'd2: cmd_o.op = OP_MSET;
            default: cmd_o.op = OP_MCLR;
         endcase
      end
   end
endmodule

// File: rtl/ipi_slice.sv
module ipi_slice (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] set_i,
   input  logic [1:0] clr_i,
   input  logic [1:0] mset_i,
   input  logic [1:0] mclr_i,
   input  logic [1:0] dlv_i,
   output logic [1:0] pend_o,
   output logic [1:0] mask_o,
   output logic [1:0] vis_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= 2'b00;
         mask_o <= 2'b11;
      end else begin
         pend_o <= (pend_o | set_i) & ~clr_i;
         mask_o <= (mask_o | mset_i | dlv_i) & ~mclr_i;
      end
   end

   assign vis_o = pend_o & ~mask_o;

   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[0] |=> pend_o[0]); // R3
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i != 2'b00) |=> ((pend_o & $past(clr_i)) == 2'b00)); // R7
   AST_DELIVER_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_i != 2'b00) |=> ((mask_o & $past(dlv_i)) == $past(dlv_i) && (pend_o & $past(dlv_i)) == $past(dlv_i))); // R6
   AST_DELIVER_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_i & ~vis_o) == 2'b00); // R5
endmodule

// File: rtl/ipi_evsel.sv
module ipi_evsel import ipi_pkg::*; (
   input  logic        hw_valid_i,
   input  logic [31:0] hw_word_i,
   input  logic [1:0]  vis_i,
   output logic [31:0] word_o,
   output logic [1:0]  dlv_o
);
   // fixed order: hardware word, then "other", then "self"
   always_comb begin
      word_o = '0;
      dlv_o  = 2'b00;
      if (hw_valid_i) begin
         word_o = hw_word_i;
      end else if (vis_i[0]) begin
         word_o = ipi_event(EV_NUM_OTH);
         dlv_o  = 2'b01;
      end else if (vis_i[1]) begin
         word_o = ipi_event(EV_NUM_SLF);
         dlv_o  = 2'b10;
      end
   end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit import ipi_pkg::*; #(
   parameter int NUM_CPU = 4,
   parameter int ADDR_W  = 16,
   localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_valid,
   input  logic                  bus_write,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [31:0]           bus_wdata,
   input  logic [CPU_W-1:0]      bus_cpu,
   output logic                  bus_rvalid,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_CPU-1:0]    hw_valid,
   input  logic [32*NUM_CPU-1:0] hw_word,
   output logic [NUM_CPU-1:0]    ipi_req
);
   if (NUM_CPU < 1 || NUM_CPU > 32) begin : g_bad_cpu
      $error("ipi_unit: NUM_CPU must lie in 1..32");
   end
   if (ADDR_W < 13) begin : g_bad_addr
      $error("ipi_unit: ADDR_W must be at least 13");
   end

   ipi_cmd_t         cmd;
   logic [CPU_W-1:0] tgt;
   logic [1:0]       wpair;
   logic             unused_wd;

   logic [1:0]  pend_a [NUM_CPU];
   logic [1:0]  mask_a [NUM_CPU];
   logic [31:0] word_a [NUM_CPU];
   logic [2*NUM_CPU-1:0] dlv_all;
   logic [31:0] rd_word;

   assign wpair     = bus_to_pair(bus_wdata);
   assign unused_wd = ^bus_wdata;

   ipi_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .CPU_W(CPU_W)) u_dec (
      .valid_i (bus_valid),
      .write_i (bus_write),
      .addr_i  (bus_addr),
      .cpu_i   (bus_cpu),
      .cmd_o   (cmd),
      .tgt_o   (tgt)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic       hit, send_hit;
      logic [1:0] set_v, clr_v, mset_v, mclr_v, dlv_v, ev_dlv, vis_v;

      assign hit      = cmd.tgt_ok && (int'(tgt) == c);
      assign send_hit = (cmd.op == OP_SEND) && cmd.tgt_ok && bus_wdata[c];
      assign set_v    = ((cmd.op == OP_SSET && hit) ? wpair : 2'b00) | {1'b0, send_hit};
      assign clr_v    = (cmd.op == OP_ACK  && hit) ? wpair : 2'b00;
      assign mset_v   = (cmd.op == OP_MSET && hit) ? wpair : 2'b00;
      assign mclr_v   = (cmd.op == OP_MCLR && hit) ? wpair : 2'b00;
      assign dlv_v    = (cmd.op == OP_EVENT && hit) ? ev_dlv : 2'b00;
      assign dlv_all[2*c +: 2] = dlv_v;

      ipi_evsel u_sel (
         .hw_valid_i (hw_valid[c]),
         .hw_word_i  (hw_word[32*c +: 32]),
         .vis_i      (vis_v),
         .word_o     (word_a[c]),
         .dlv_o      (ev_dlv)
      );

      ipi_slice u_slice (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_v),
         .clr_i  (clr_v),
         .mset_i (mset_v),
         .mclr_i (mclr_v),
         .dlv_i  (dlv_v),
         .pend_o (pend_a[c]),
         .mask_o (mask_a[c]),
         .vis_o  (vis_v)
      );

      assign ipi_req[c] = |vis_v;
   end

   always_comb begin
      rd_word = '0;
      if (cmd.tgt_ok) begin
         unique case (cmd.op)
            OP_WHOAMI:  rd_word = 32'(bus_cpu);
            OP_EVENT:   rd_word = word_a[tgt];
            OP_RD_PEND: rd_word = pair_to_bus(pend_a[tgt]);
            OP_RD_MASK: rd_word = pair_to_bus(mask_a[tgt]);
            default:    rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_valid && !bus_write;
         bus_rdata  <= rd_word;
      end
   end

   AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write) |=> bus_rvalid); // R2
   AST_ONE_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dlv_all)); // R6
   AST_HW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.op == OP_EVENT && cmd.tgt_ok && hw_valid[tgt]) |-> (dlv_all == '0)); // R5
   AST_NO_WRITE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write) |=> !bus_rvalid); // R2
endmodule

// File: tb/sim_ipi_unit.sv
`timescale 1ns/1ps
module sim_ipi_unit;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0, bus_write = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [1:0]    bus_cpu = '0;
   logic          bus_rvalid;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] hw_valid = '0;
   logic [32*NC-1:0] hw_word = '0;
   logic [NC-1:0] ipi_req;

   int checks = 0, errors = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   ipi_unit #(.NUM_CPU(NC), .ADDR_W(16)) u0 (.*);

   // monitor: pop expected read data when a response appears
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected response: actual %h expected none", bus_rdata);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic access(input logic w, input logic [1:0] cpu, input logic [15:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = w; bus_cpu = cpu; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic wr(input logic [1:0] cpu, input logic [15:0] a, input logic [31:0] d);
      access(1'b1, cpu, a, d);
   endtask

   task automatic rd(input logic [1:0] cpu, input logic [15:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      access(1'b0, cpu, a, 32'd0);
   endtask

   task automatic chk_req(input logic [NC-1:0] e, input string t);
      checks++;
      if (ipi_req !== e) begin
         errors++;
         $display("FAIL %s: actual ipi_req %b expected %b", t, ipi_req, e);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (bus_rvalid !== 1'b0) begin
         errors++;
         $display("FAIL R1 rvalid: actual %b expected 0", bus_rvalid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk_req(4'b0000, "R1 reset request");
      rd(0, 16'h0010, 32'h8000_0001, "R1 reset mask");
      rd(0, 16'h000C, 32'h0000_0000, "R1 reset pending");
      rd(2, 16'h0000, 32'd2, "R2 whoami cpu2");
      rd(3, 16'h0000, 32'd3, "R2 whoami cpu3");
      rd(0, 16'h0004, 32'h0, "R5 empty event");

      // broadcast send to cpus 1 and 2, bit 4 beyond range
      wr(0, 16'h0008, 32'h0000_0016);
      rd(1, 16'h000C, 32'h0000_0001, "R3 cpu1 other pending");
      rd(0, 16'h000C, 32'h0000_0000, "R3 sender untouched");
      chk_req(4'b0000, "R4 masked pending no request");

      wr(1, 16'h0014, 32'h8000_0001);
      chk_req(4'b0010, "R8 unmask raises request");
      wr(1, 16'h0018, 32'h8000_0000);
      rd(1, 16'h000C, 32'h8000_0001, "R9 self set");
      rd(1, 16'h0004, 32'h0004_0001, "R5 other first");
      chk_req(4'b0010, "R6 self still requests");
      rd(1, 16'h0010, 32'h0000_0001, "R6 other masked by delivery");
      rd(1, 16'h0004, 32'h0004_0002, "R5 self second");
      chk_req(4'b0000, "R6 both delivered");
      rd(1, 16'h000C, 32'h8000_0001, "R6 pending kept");
      wr(1, 16'h000C, 32'h7FFF_FFFF);
      rd(1, 16'h000C, 32'h8000_0000, "R7 ack other only");
      wr(1, 16'h000C, 32'h8000_0000);
      rd(1, 16'h000C, 32'h0000_0000, "R7 ack self");

      // hardware word takes precedence on cpu2
      wr(2, 16'h0014, 32'h0000_0001);
      chk_req(4'b0100, "R4 cpu2 request");
      hw_valid[2] = 1'b1;
      hw_word[64 +: 32] = 32'h0001_0123;
      rd(2, 16'h0004, 32'h0001_0123, "R5 hardware word first");
      rd(2, 16'h0010, 32'h8000_0000, "R6 hardware leaves mask");
      hw_valid[2] = 1'b0;
      rd(2, 16'h0004, 32'h0004_0001, "R5 ipi after hardware");
      rd(2, 16'h0010, 32'h8000_0001, "R6 cpu2 masked");
      chk_req(4'b0000, "R6 cpu2 request dropped");

      // per-cpu views acting on cpu3 from cpu0
      wr(0, 16'h1180, 32'h8000_0000);
      rd(3, 16'h000C, 32'h8000_0000, "R10 view set");
      wr(0, 16'h118C, 32'h8000_0000);
      chk_req(4'b1000, "R10 view mask clear");
      wr(0, 16'h1188, 32'h8000_0000);
      chk_req(4'b0000, "R10 view mask set");
      wr(0, 16'h118C, 32'h8000_0000);
      wr(0, 16'h1184, 32'h8000_0000);
      chk_req(4'b0000, "R10 view clear");
      rd(3, 16'h000C, 32'h0, "R10 view clear pending");

      // view beyond NUM_CPU is ignored; unmask cpu0 so effect would show
      wr(0, 16'h0014, 32'h8000_0001);
      wr(0, 16'h1280, 32'h8000_0001);
      chk_req(4'b0000, "R10 out of range view");
      rd(0, 16'h000C, 32'h0, "R10 out of range pending");
      wr(0, 16'h0010, 32'h0000_0001);
      rd(0, 16'h0010, 32'h0000_0001, "R8 mask set other");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2 missing responses: actual %0d left expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule